// File: doc/BRIEF.md
# Two-wire serial data and status register unit

This unit connects a processor register port to the bit engine of a two-wire serial controller. It holds two registers. The data register serves as the bus shift register. Each bit sent to the bus is driven from its top bit, and the level sampled from the data line enters at its bottom bit. After a byte, the register therefore holds whatever byte actually appeared on the wire. Because of this, a byte that loses arbitration partway through is still captured in full.

The status register publishes a state code supplied by the protocol engine. That code becomes visible one cycle after the interrupt flag rises, and it falls back to the idle word one cycle after the flag drops. The interrupt flag is set by a hardware pulse and cleared by software. While the flag is high, the data register is frozen against shifting and is open to processor writes. While the flag is low, processor writes to the data register are dropped.

The acknowledge bit never passes through this unit. The engine drives and samples it on its own.

Top module: `twb_regs`

## Requirements
- R1: After reset the data register reads 0xFF, the status register reads 0xF8, irq_flag is 0 and sda_out is 1.
- R2: A hw_set pulse makes irq_flag 1 on the next cycle. A flag_clr pulse without hw_set makes it 0 on the next cycle. When both arrive in the same cycle, the flag ends up set.
- R3: The status register (cpu_sel=1) shows the code taken at the last hw_set, placed in bits 7..3, starting two cycles after that hw_set (one cycle after irq_flag rises). Bits 2..0 always read 0.
- R4: One cycle after irq_flag is seen low, the status register reads the idle word 0xF8.
- R5: A processor write with cpu_sel=1 has no effect on the status register.
- R6: A processor write with cpu_sel=0 loads cpu_wdata into the data register on the next cycle only if irq_flag is 1; otherwise the data register is unchanged.
- R7: While irq_flag is 0, each shift_en cycle moves the data register one place toward bit 7 and loads sda_in into bit 0. sda_out always equals bit 7 of the data register, and after eight shifts the register equals the eight sampled bits, first-sampled in bit 7.
- R8: While irq_flag is 1, shift_en is ignored, and the data register changes only through an R6 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register select: 0 data, 1 status |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| flag_clr | input | 1 | Software flag clear strobe |
| shift_en | input | 1 | Bit shift strobe from the bit engine |
| sda_in | input | 1 | Sampled data line level |
| hw_set | input | 1 | Hardware flag set pulse |
| hw_code | input | 5 | State code from the protocol engine |
| sda_out | output | 1 | Data bit to drive onto the bus |
| rd_data | output | 8 | Read data of the selected register |
| irq_flag | output | 1 | Interrupt flag |

## Verification
The bench targets four corner cases.

The first is a set and a clear arriving in the same cycle. A design that gives the clear priority would drop a pending event.

The second is the exact cycle in which the status word changes on the way in and on the way out. A design without the one-cycle lag would show the code too early, and one that decodes the flag late would keep a stale code after the clear.

The third is a data write or a shift arriving on the wrong side of the flag. A design that got this wrong would corrupt a byte in flight, or disturb a byte that software is reading.

The fourth is a long byte shifted in with bits that differ from the ones driven out. A design that shifts in the wrong direction, or that does not capture the bus, would fail to end with the bus byte.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_STAT = 1'b1
  } twb_sel_e;

  function automatic logic [7:0] idle_word8();
    return 8'hF8;
  endfunction
endpackage

// File: rtl/twb_flag.sv
module twb_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)
      flag_o <= 1'b0;
    else if (set_i)
      flag_o <= 1'b1;
    else if (clr_i)
      flag_o <= 1'b0;
  end
endmodule

// File: rtl/twb_status.sv
module twb_status #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] stat_o
);
  localparam int PAD_W = DATA_W - CODE_W;
  localparam logic [CODE_W-1:0] IDLE_CODE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_pub;
  logic [DATA_W-1:0] word_next;

  always_ff @(posedge clk) begin
    if (rst)
      code_q <= IDLE_CODE;
    else if (load_i)
      code_q <= code_i;
  end

  assign code_pub = flag_i ? code_q : IDLE_CODE;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_next = {code_pub, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign word_next = code_pub;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      stat_o <= word_next & {DATA_W{1'b0}} | {IDLE_CODE, {PAD_W{1'b0}}};
    else
      stat_o <= word_next;
  end
endmodule

// File: rtl/twb_shift.sv
module twb_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  logic wr_ok;
  logic sh_ok;

  assign wr_ok = wr_i & flag_i;
  assign sh_ok = shift_i & ~flag_i;

  always_ff @(posedge clk) begin
    if (rst)
      data_o <= {DATA_W{1'b1}};
    else if (wr_ok)
      data_o <= wdata_i;
    else if (sh_ok)
      data_o <= {data_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/twb_regs.sv
module twb_regs
  import twb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              flag_clr,
  input  logic              shift_en,
  input  logic              sda_in,
  input  logic              hw_set,
  input  logic [CODE_W-1:0] hw_code,
  output logic              sda_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_flag
);
  logic [DATA_W-1:0] data_word;
  logic [DATA_W-1:0] stat_word;
  logic              data_wr;

  assign data_wr = cpu_wr & (cpu_sel == SEL_DATA);

  twb_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (hw_set),
    .clr_i  (flag_clr),
    .flag_o (irq_flag)
  );

  twb_status #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .load_i (hw_set),
    .code_i (hw_code),
    .flag_i (irq_flag),
    .stat_o (stat_word)
  );

  twb_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .flag_i  (irq_flag),
    .wr_i    (data_wr),
    .wdata_i (cpu_wdata),
    .shift_i (shift_en),
    .bit_i   (sda_in),
    .data_o  (data_word)
  );

  assign sda_out = data_word[DATA_W-1];
  assign rd_data = (cpu_sel == SEL_STAT) ? stat_word : data_word;
endmodule

// File: rtl/twb_regs_chk.sv
module twb_regs_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_sel,
  input logic              cpu_wr,
  input logic              flag_clr,
  input logic              shift_en,
  input logic              sda_in,
  input logic              hw_set,
  input logic [CODE_W-1:0] hw_code,
  input logic              irq_flag,
  input logic [DATA_W-1:0] data_word,
  input logic [DATA_W-1:0] stat_word
);
  localparam int PAD_W = DATA_W - CODE_W;

  p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> irq_flag);

  p_flag_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !hw_set) |=> !irq_flag);

  p_stat_lag_r3: assert property (@(posedge clk) disable iff (rst)
    (hw_set ##1 !hw_set) |=> (stat_word[DATA_W-1:PAD_W] == $past(hw_code, 2)));

  p_stat_pad_r3: assert property (@(posedge clk) disable iff (rst)
    stat_word[PAD_W-1:0] == '0);

  p_stat_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !irq_flag |=> (stat_word == {{CODE_W{1'b1}}, {PAD_W{1'b0}}}));

  p_wr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_sel && !irq_flag && !shift_en) |=> $stable(data_word));

  p_shift_in_r7: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !irq_flag) |=> (data_word[0] == $past(sda_in)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !(cpu_wr && !cpu_sel)) |=> $stable(data_word));
endmodule

bind twb_regs twb_regs_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_sel   (cpu_sel),
  .cpu_wr    (cpu_wr),
  .flag_clr  (flag_clr),
  .shift_en  (shift_en),
  .sda_in    (sda_in),
  .hw_set    (hw_set),
  .hw_code   (hw_code),
  .irq_flag  (irq_flag),
  .data_word (data_word),
  .stat_word (stat_word)
);

// File: tb/twb_regs_tb.sv
`timescale 1ns/1ps
module twb_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_sel, cpu_wr, flag_clr, shift_en, sda_in, hw_set;
  logic [7:0] cpu_wdata;
  logic [4:0] hw_code;
  logic       sda_out, irq_flag;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       m_flag;
  logic [4:0] m_code;
  logic [7:0] m_stat;
  logic [7:0] m_data;

  always #2.5 clk = ~clk;

  twb_regs dut_i (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .flag_clr(flag_clr), .shift_en(shift_en),
    .sda_in(sda_in), .hw_set(hw_set), .hw_code(hw_code),
    .sda_out(sda_out), .rd_data(rd_data), .irq_flag(irq_flag)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_wr = 0; flag_clr = 0; shift_en = 0; hw_set = 0;
    sda_in = 0; cpu_wdata = 8'h00; hw_code = 5'h00;
  endtask

  // Model step from requirements R2, R3, R4, R6, R7, R8.
  task automatic model_step();
    logic       n_flag;
    logic [4:0] n_code;
    logic [7:0] n_stat;
    logic [7:0] n_data;
    n_flag = hw_set ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    n_code = hw_set ? hw_code : m_code;
    n_stat = m_flag ? {m_code, 3'b000} : 8'hF8;
    n_data = m_data;
    if (m_flag && cpu_wr && !cpu_sel) n_data = cpu_wdata;
    else if (!m_flag && shift_en) n_data = {m_data[6:0], sda_in};
    m_flag = n_flag; m_code = n_code; m_stat = n_stat; m_data = n_data;
  endtask

  // Apply current inputs for one clock, then compare away from the edge.
  task automatic step();
    model_step();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2 flag"}, {7'd0, irq_flag}, {7'd0, m_flag});
    check({tag, " R7 sda_out"}, {7'd0, sda_out}, {7'd0, m_data[7]});
    cpu_sel = 1'b1; #0.1;
    check({tag, " R3 R4 status"}, rd_data, m_stat);
    cpu_sel = 1'b0; #0.1;
    check({tag, " R6 R8 data"}, rd_data, m_data);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] pat;
    seed = 32'd1234;
    void'($urandom(seed));
    idle_inputs(); cpu_sel = 0; rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    m_flag = 0; m_code = 5'h1F; m_stat = 8'hF8; m_data = 8'hFF;

    // R1 reset values
    check("R1 flag", {7'd0, irq_flag}, 8'd0);
    check("R1 sda_out", {7'd0, sda_out}, 8'd1);
    cpu_sel = 1; #0.1; check("R1 status", rd_data, 8'hF8);
    cpu_sel = 0; #0.1; check("R1 data", rd_data, 8'hFF);

    // R6 write while flag clear is ignored
    cpu_wr = 1; cpu_wdata = 8'h3C; step();
    check("R6 write ignored", rd_data, 8'hFF);

    // R7 eight shifts capture bus byte, MSB first
    pat = 8'hA6;
    for (int i = 7; i >= 0; i--) begin
      shift_en = 1; sda_in = pat[i]; step();
    end
    check("R7 byte captured", rd_data, 8'hA6);
    check("R7 sda_out top bit", {7'd0, sda_out}, 8'd1);

    // R2 and R3: set, lag of status
    hw_set = 1; hw_code = 5'h0B; step();
    check("R2 flag set", {7'd0, irq_flag}, 8'd1);
    cpu_sel = 1; #0.1; check("R3 status still idle", rd_data, 8'hF8);
    step();
    cpu_sel = 1; #0.1; check("R3 status code", rd_data, {5'h0B, 3'b000});
    cpu_sel = 0; #0.1;

    // R8 shift ignored while flag set
    shift_en = 1; sda_in = 0; step();
    check("R8 shift ignored", rd_data, 8'hA6);

    // R5 status write ignored
    cpu_sel = 1; cpu_wr = 1; cpu_wdata = 8'h00; step();
    cpu_sel = 1; #0.1; check("R5 status write ignored", rd_data, {5'h0B, 3'b000});
    cpu_sel = 0; #0.1;

    // R6 write while flag set accepted
    cpu_wr = 1; cpu_wdata = 8'h5A; step();
    check("R6 write accepted", rd_data, 8'h5A);

    // R2 set wins over simultaneous clear
    hw_set = 1; flag_clr = 1; hw_code = 5'h14; step();
    check("R2 set priority", {7'd0, irq_flag}, 8'd1);

    // R4 clear then status idle one cycle later
    flag_clr = 1; step();
    check("R2 flag cleared", {7'd0, irq_flag}, 8'd0);
    cpu_sel = 1; #0.1; check("R4 status before idle", rd_data, {5'h14, 3'b000});
    step();
    cpu_sel = 1; #0.1; check("R4 status idle", rd_data, 8'hF8);
    cpu_sel = 0; #0.1;

    // Randomized mix
    for (int n = 0; n < 3000; n++) begin
      hw_set    = ($urandom % 8) == 0;
      flag_clr  = ($urandom % 6) == 0;
      cpu_wr    = ($urandom % 4) == 0;
      shift_en  = ($urandom % 2) == 0;
      sda_in    = $urandom % 2;
      cpu_sel   = $urandom % 2;
      cpu_wdata = $urandom % 256;
      hw_code   = $urandom % 32;
      step();
      check_all("random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule